// File: doc/BRIEF.md
# Fractional-N Divide Sequencer with Selectable Noise-Shaping Order

This block produces the instantaneous feedback divide value for a fractional-N frequency synthesizer. On every reference-rate tick it adds a small signed correction to an integer divide value. Over time the corrections average to the fraction `frac_num / frac_den`. The correction comes from a chain of up to four cascaded accumulators. Each accumulator wraps modulo the denominator, and the overflow bits of the stages pass through difference networks, so that the quantization error is pushed toward high offset frequencies.

The noise-shaping order is chosen at run time: integer-only, or order one to four. An optional pseudo-random dither can be added to the first accumulator at one of four strengths. Dither is held off automatically in integer mode, in first order, and whenever the numerator is zero. All configuration inputs are sampled only on a tick. A change of order clears every accumulator and every history register.

Top module: `fracn_dsm`

## Requirements
- R1: After reset `div_val` is 0 and the active order is third order. The first tick whose order field holds a different legal order (for example 1) is therefore a clearing tick.
- R2: `div_val` changes only on a clock edge where `ref_tick` is high. Between ticks, changes on any configuration input have no effect on it.
- R3: `order_sel` encoding: 0 integer mode, 1 to 4 first to fourth order. Codes 5, 6 and 7 behave exactly as code 0.
- R4: In integer mode every tick loads `div_val` with that tick's `int_n`, unchanged.
- R5: In first order, on the t-th tick after a clearing tick, `div_val` = N + floor(t·num/den) − floor((t−1)·num/den). Any `frac_den` consecutive ticks therefore sum to N·den + num.
- R6: On a non-clearing tick of order k (1 to 4), `div_val − int_n` lies in [−(2^(k−1)−1), 2^(k−1)]. This holds with or without dither.
- R7: For orders 2 to 4 without dither, the running sum of `div_val` over the first T ticks after a clearing tick differs from N·T + floor(T·num/den) by no less than −3 and no more than +4.
- R8: A tick whose legal order differs from the active order outputs exactly `int_n` and zeroes all accumulators and difference history. The ticks that follow start from the zero state.
- R9: `dith_sel` encoding: 0 none, 1 weak, 2 medium, 3 strong. These add 0, 1, 4 or 16 to the first accumulator input on ticks where a pseudo-random bit is set. With order 2 to 4, a nonzero numerator and strength 3, the output sequence differs from the undithered one. The caller keeps num + 16 < den when dithering.
- R10: Dither has no effect in integer mode, in first order, or when `frac_num` is 0. With a zero numerator, every order outputs exactly `int_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference-rate strobe; one modulator step per high cycle |
| int_n | input | N_W | Integer part of the divide value (expected at least 7) |
| frac_num | input | F_W | Fractional numerator, below `frac_den` |
| frac_den | input | F_W | Fractional denominator, at least 2 |
| order_sel | input | 3 | Noise-shaping order select |
| dith_sel | input | 2 | Dither strength select |
| div_val | output | N_W+1 | Registered instantaneous divide value |

## Verification
The first-order sweep covers every numerator against a small denominator, including 0 and den−1. A stage that wraps at the wrong threshold, or that loses its residue, would shift the carry positions and break the exact per-tick sequence and the window sums. Orders two to four are checked tick by tick against their correction bounds and their running-mean bound. A difference network with a wrong sign or coefficient would drift out of range or lose the mean. Order switching, illegal codes, dither on a zero numerator and the post-reset default order are each exercised, because a design that skipped the clear, decoded 5 to 7 as a modulator, or let dither leak into first order would leave visible offsets in `div_val`.

// File: rtl/fracn_dsm_pkg.sv
package fracn_dsm_pkg;

   typedef enum logic [1:0] {
      DITH_NONE   = 2'd0,
      DITH_WEAK   = 2'd1,
      DITH_MEDIUM = 2'd2,
      DITH_STRONG = 2'd3
   } dith_strength_e;

   // binomial coefficient, used for the (1 - z^-1)^n difference taps
   function automatic int binom(input int n, input int k);
      int r;
      r = 1;
      for (int i = 0; i < k; i++) begin
         r = (r * (n - i)) / (i + 1);
      end
      return r;
   endfunction

   // upper bound of the correction for order k
   function automatic int corr_hi(input int k);
      return (k == 0) ? 0 : (1 << (k - 1));
   endfunction

   // magnitude of the lower bound of the correction for order k
   function automatic int corr_lo(input int k);
      return (k == 0) ? 0 : ((1 << (k - 1)) - 1);
   endfunction

   function automatic int dith_scale(input dith_strength_e s);
      case (s)
         DITH_WEAK:   return 1;
         DITH_MEDIUM: return 4;
         DITH_STRONG: return 16;
         default:     return 0;
      endcase
   endfunction

endpackage

// File: rtl/fracn_dsm_acc.sv
module fracn_dsm_acc #(
   parameter int F_W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           adv,
   input  logic           clr,
   input  logic [F_W-1:0] den,
   input  logic [F_W-1:0] inc,
   output logic [F_W-1:0] res_nxt,
   output logic           carry
);

   logic [F_W-1:0] acc_q;
   logic [F_W:0]   sum_w;
   logic [F_W:0]   wrap_w;

   assign sum_w   = {1'b0, acc_q} + {1'b0, inc};
   assign wrap_w  = sum_w - {1'b0, den};
   assign carry   = (sum_w >= {1'b0, den});
   assign res_nxt = carry ? wrap_w[F_W-1:0] : sum_w[F_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
      end else if (adv) begin
         acc_q <= res_nxt;
      end
   end

   // residue stays below the modulus whenever the step input is legal
   AST_RES_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && inc < den && acc_q < den) |=> (acc_q < $past(den))); // R5

endmodule

// File: rtl/fracn_dsm_diff.sv
module fracn_dsm_diff
   import fracn_dsm_pkg::*;
#(
   parameter int DEPTH = 0,
   parameter int CW    = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv,
   input  logic                 clr,
   input  logic                 c_in,
   output logic signed [CW-1:0] term
);

   logic [DEPTH:0] taps;

   generate
      if (DEPTH == 0) begin : g_nohist
         assign taps = c_in;
      end else begin : g_hist
         logic [DEPTH-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= '0;
            end else if (clr) begin
               hist_q <= '0;
            end else if (adv) begin
               hist_q <= (hist_q << 1) | DEPTH'(c_in);
            end
         end
         assign taps = {hist_q, c_in};
      end
   endgenerate

   always_comb begin
      logic signed [CW-1:0] acc_v;
      acc_v = '0;
      for (int j = 0; j <= DEPTH; j++) begin
         if (taps[j]) begin
            if ((j % 2) == 1) acc_v = acc_v - signed'(CW'(binom(DEPTH, j)));
            else              acc_v = acc_v + signed'(CW'(binom(DEPTH, j)));
         end
      end
      term = acc_v;
   end

endmodule

// File: rtl/fracn_dsm_lfsr.sv
module fracn_dsm_lfsr #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   TAPS = 16'hB400,
   parameter logic [W-1:0]   SEED = 16'hACE1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   output logic rnd_bit
);

   logic [W-1:0] lfsr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lfsr_q <= SEED;
      end else if (adv) begin
         lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : '0);
      end
   end

   assign rnd_bit = lfsr_q[0];

   initial begin
      assert (SEED != '0) else $fatal(1, "lfsr seed must be nonzero");
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (lfsr_q != '0)); // R9

endmodule

// File: rtl/fracn_dsm.sv
module fracn_dsm
   import fracn_dsm_pkg::*;
#(
   parameter int N_W       = 10,
   parameter int F_W       = 16,
   parameter int MAX_ORDER = 4,
   parameter bit DITHER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic [N_W-1:0]   int_n,
   input  logic [F_W-1:0]   frac_num,
   input  logic [F_W-1:0]   frac_den,
   input  logic [2:0]       order_sel,
   input  logic [1:0]       dith_sel,
   output logic [N_W:0]     div_val
);

   localparam int OUT_W  = N_W + 1;
   localparam int SUM_W  = OUT_W + 1;
   localparam int CORR_W = MAX_ORDER + 2;
   localparam logic [2:0] RESET_ORDER = 3'd3;

   initial begin
      assert (MAX_ORDER >= 1 && MAX_ORDER <= 4) else $fatal(1, "MAX_ORDER out of range");
      assert (F_W >= 6) else $fatal(1, "F_W too small for dither");
      assert (N_W >= 4) else $fatal(1, "N_W too small");
      assert (SUM_W >= CORR_W) else $fatal(1, "output too narrow for correction");
   end

   // ---------------- order decode and clear ----------------
   logic [2:0] ord_q;
   logic [2:0] eff_ord;
   logic       clr;
   logic       adv;

   assign eff_ord = (int'(order_sel) > MAX_ORDER) ? 3'd0 : order_sel;
   assign clr     = ref_tick && (eff_ord != ord_q);
   assign adv     = ref_tick && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ord_q <= RESET_ORDER;
      end else if (ref_tick) begin
         ord_q <= eff_ord;
      end
   end

   // ---------------- dither ----------------
   logic           rnd_bit;
   logic           dith_on;
   logic [F_W-1:0] dith_amt;

   generate
      if (DITHER_EN) begin : g_dither
         fracn_dsm_lfsr #(.W(16)) u_lfsr (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (ref_tick),
            .rnd_bit (rnd_bit)
         );
      end else begin : g_nodither
         assign rnd_bit = 1'b0;
      end
   endgenerate

   assign dith_on  = (eff_ord >= 3'd2) && (frac_num != '0) && (dith_sel != 2'd0);
   assign dith_amt = (dith_on && rnd_bit) ?
                     F_W'(dith_scale(dith_strength_e'(dith_sel))) : '0;

   // ---------------- accumulator cascade ----------------
   logic [F_W-1:0]          inc_w   [MAX_ORDER];
   logic [F_W-1:0]          res_w   [MAX_ORDER];
   logic [MAX_ORDER-1:0]    car_w;
   logic [MAX_ORDER-1:0]    en_w;
   logic signed [CORR_W-1:0] term_w [MAX_ORDER];

   genvar s;
   generate
      for (s = 0; s < MAX_ORDER; s++) begin : g_stage
         assign en_w[s] = (eff_ord >= 3'(s + 1));

         if (s == 0) begin : g_first
            assign inc_w[s] = en_w[s] ? (frac_num + dith_amt) : '0;
         end else begin : g_next
            assign inc_w[s] = en_w[s] ? res_w[s-1] : '0;
         end

         logic car_raw;

         fracn_dsm_acc #(.F_W(F_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (adv),
            .clr     (clr),
            .den     (frac_den),
            .inc     (inc_w[s]),
            .res_nxt (res_w[s]),
            .carry   (car_raw)
         );

         assign car_w[s] = car_raw && en_w[s];

         fracn_dsm_diff #(.DEPTH(s), .CW(CORR_W)) u_diff (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv),
            .clr   (clr),
            .c_in  (car_w[s]),
            .term  (term_w[s])
         );
      end
   endgenerate

   // ---------------- correction and output ----------------
   logic signed [CORR_W-1:0] corr_sum;
   logic signed [SUM_W-1:0]  nxt_s;

   always_comb begin
      logic signed [CORR_W-1:0] acc_v;
      acc_v = '0;
      for (int k = 0; k < MAX_ORDER; k++) begin
         acc_v = acc_v + term_w[k];
      end
      corr_sum = acc_v;
   end

   assign nxt_s = $signed({2'b00, int_n}) +
                  $signed({{(SUM_W-CORR_W){corr_sum[CORR_W-1]}}, corr_sum});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_val <= '0;
      end else if (ref_tick) begin
         div_val <= clr ? {1'b0, int_n} : nxt_s[OUT_W-1:0];
      end
   end

   // ---------------- assertions ----------------
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_tick |=> $stable(div_val)); // R2

   AST_INT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_tick && (order_sel == 3'd0 || int'(order_sel) > MAX_ORDER))
      |=> (div_val == {1'b0, $past(int_n)})); // R3 R4

   AST_CLEAR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (div_val == {1'b0, $past(int_n)})); // R8

   AST_CORR_HI: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (SUM_W'(div_val) <=
               SUM_W'($past(int_n)) + SUM_W'(corr_hi(int'($past(eff_ord)))))); // R6

   AST_CORR_LO: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (SUM_W'(div_val) + SUM_W'(corr_lo(int'($past(eff_ord)))) >=
               SUM_W'($past(int_n)))); // R6

   AST_ZERO_NUM: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && frac_num == '0 && $past(ref_tick) == 1'b0 && car_w == '0)
      |=> (SUM_W'(div_val) + SUM_W'(corr_lo(int'($past(eff_ord)))) >=
           SUM_W'($past(int_n)))); // R10

endmodule

// File: tb/fracn_dsm_tb_top.sv
module fracn_dsm_tb_top;

   localparam int N_W = 10;
   localparam int F_W = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ref_tick = 1'b0;
   logic [N_W-1:0] int_n = '0;
   logic [F_W-1:0] frac_num = '0;
   logic [F_W-1:0] frac_den = 16'd13;
   logic [2:0]     order_sel = 3'd3;
   logic [1:0]     dith_sel = 2'd0;
   logic [N_W:0]   div_val;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;
   int  cur_ord  = 3;

   always #10 clk = ~clk;

   fracn_dsm #(.N_W(N_W), .F_W(F_W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_tick  (ref_tick),
      .int_n     (int_n),
      .frac_num  (frac_num),
      .frac_den  (frac_den),
      .order_sel (order_sel),
      .dith_sel  (dith_sel),
      .div_val   (div_val)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one tick: strobe held high for one clock edge, output sampled at the next falling edge
   task automatic tick();
      @(negedge clk) ref_tick = 1'b1;
      @(negedge clk) ref_tick = 1'b0;
   endtask

   task automatic set_cfg(input int n, input int num, input int den, input int ord, input int dith);
      int_n     = N_W'(n);
      frac_num  = F_W'(num);
      frac_den  = F_W'(den);
      order_sel = 3'(ord);
      dith_sel  = 2'(dith);
   endtask

   // force a fresh start of the target order: two clearing ticks
   task automatic restart(input int ord);
      int other;
      other = (ord == 1) ? 2 : 1;
      order_sel = 3'(other);
      tick();
      chk(longint'(div_val) == longint'(int_n), "R8", longint'(div_val), longint'(int_n));
      order_sel = 3'(ord);
      tick();
      chk(longint'(div_val) == longint'(int_n), "R8", longint'(div_val), longint'(int_n));
      cur_ord = ord;
   endtask

   int seq_a [64];

   initial begin
      // ---- R1: reset value and default order ----
      repeat (3) @(negedge clk);
      chk(div_val == '0, "R1 reset value", longint'(div_val), 0);
      rst_n = 1'b1;
      @(negedge clk);
      set_cfg(100, 12, 13, 1, 0);
      tick();
      chk(longint'(div_val) == 100, "R1 first tick clears", longint'(div_val), 100);
      tick();
      chk(longint'(div_val) == 100, "R1 step t=1", longint'(div_val), 100);
      tick();
      chk(longint'(div_val) == 101, "R1 step t=2", longint'(div_val), 101);
      cur_ord = 1;

      // ---- R5 / R10: exhaustive first-order sweep over den = 13, dither on for odd num ----
      for (int num = 0; num < 13; num++) begin
         longint wsum;
         set_cfg(100 + num, num, 13, 1, (num % 2 == 1) ? 3 : 0);
         restart(1);
         wsum = 0;
         for (int t = 1; t <= 26; t++) begin
            longint exp_v;
            tick();
            exp_v = (100 + num) + (longint'(t) * num) / 13 - (longint'(t - 1) * num) / 13;
            chk(longint'(div_val) == exp_v, "R5 R10 first order step", longint'(div_val), exp_v);
            if (t <= 13) wsum += longint'(div_val);
         end
         chk(wsum == longint'(100 + num) * 13 + num, "R5 window sum", wsum,
             longint'(100 + num) * 13 + num);
      end

      // ---- R5: large denominator ----
      set_cfg(517, 333, 1000, 1, 0);
      restart(1);
      for (int t = 1; t <= 40; t++) begin
         longint exp_v;
         tick();
         exp_v = 517 + (longint'(t) * 333) / 1000 - (longint'(t - 1) * 333) / 1000;
         chk(longint'(div_val) == exp_v, "R5 den 1000", longint'(div_val), exp_v);
      end

      // ---- R4 / R10: integer mode, N changing per tick, strong dither present ----
      set_cfg(50, 77, 97, 0, 3);
      tick();
      for (int i = 0; i < 20; i++) begin
         int_n = N_W'(20 + 37 * i);
         tick();
         chk(longint'(div_val) == longint'(20 + 37 * i), "R4 R10 integer mode",
             longint'(div_val), longint'(20 + 37 * i));
      end

      // ---- R3: illegal codes behave as integer mode ----
      for (int code = 5; code <= 7; code++) begin
         set_cfg(300 + code, 77, 97, code, 2);
         for (int i = 0; i < 4; i++) begin
            tick();
            chk(longint'(div_val) == longint'(300 + code), "R3 illegal order code",
                longint'(div_val), longint'(300 + code));
         end
      end
      cur_ord = 0;

      // ---- R2: no tick, no change ----
      set_cfg(250, 0, 97, 0, 0);
      tick();
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         set_cfg(260 + i, 5 + i, 97, 4, 3);
         @(negedge clk);
         chk(longint'(div_val) == 250, "R2 hold between ticks", longint'(div_val), 250);
      end
      set_cfg(260, 0, 97, 0, 0);
      tick();
      chk(longint'(div_val) == 260, "R2 load on tick", longint'(div_val), 260);

      // ---- R10: zero numerator with higher orders and dither ----
      for (int ord = 2; ord <= 4; ord++) begin
         set_cfg(400, 0, 97, ord, 3);
         restart(ord);
         for (int t = 0; t < 20; t++) begin
            tick();
            chk(longint'(div_val) == 400, "R10 zero numerator", longint'(div_val), 400);
         end
      end

      // ---- R6 / R7: orders 2..4, several numerators ----
      for (int ord = 2; ord <= 4; ord++) begin
         for (int ni = 0; ni < 3; ni++) begin
            int num;
            longint rsum;
            num = (ni == 0) ? 1 : (ni == 1) ? 45 : 96;
            set_cfg(300, num, 97, ord, 0);
            restart(ord);
            rsum = 0;
            for (int t = 1; t <= 150; t++) begin
               longint corr, err;
               tick();
               corr = longint'(div_val) - 300;
               chk(corr <= (64'sd1 <<< (ord - 1)) && corr >= -((64'sd1 <<< (ord - 1)) - 1),
                   "R6 correction range", corr, 64'sd1 <<< (ord - 1));
               rsum += longint'(div_val);
               err = rsum - (300 * longint'(t) + (longint'(t) * num) / 97);
               chk(err >= -3 && err <= 4, "R7 running mean", err, 0);
            end
         end
      end

      // ---- R9: strong dither changes the third-order sequence ----
      begin
         int diffs;
         set_cfg(400, 37, 200, 3, 0);
         restart(3);
         for (int t = 0; t < 64; t++) begin
            tick();
            seq_a[t] = int'(div_val);
         end
         set_cfg(400, 37, 200, 3, 3);
         restart(3);
         diffs = 0;
         for (int t = 0; t < 64; t++) begin
            longint corr;
            tick();
            corr = longint'(div_val) - 400;
            chk(corr <= 4 && corr >= -3, "R6 R9 dithered range", corr, 4);
            if (int'(div_val) != seq_a[t]) diffs++;
         end
         chk(diffs > 0, "R9 dither alters sequence", diffs, 1);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule